// File: doc/BRIEF.md
# Three-Bus Accumulator Processor Core

This block is a small accumulator machine. A control state machine runs every instruction as a series of bus-gating and register-load steps. There are three internal buses. The address bus feeds the memory address register. The memory bus carries read data into the instruction register or into the second ALU operand. The result bus carries the ALU output to the accumulator and to the memory write port. The accumulator is wired straight to the first ALU operand and never travels over a bus.

The core works with a synchronous single-port memory that has one cycle of read latency. Every access is one strobe cycle. A read/write select is high for a read and low for a write. Each instruction word is one memory word:
- The top four bits, [15:12], hold the opcode.
- The low twelve bits, [11:0], hold a memory address.

The core runs four instructions:
- 0001 loads the accumulator from memory.
- 0010 adds a memory word to the accumulator.
- 0011 stores the accumulator to memory.
- 1111 halts the core.

Any other opcode is skipped.

Top module: `acc_core`

## Requirements
- R1: A synchronous reset clears the program counter, the accumulator and the instruction register, and drops `halted`. After reset is released, the first access is an instruction read at address 0. The accumulator reads back as 0 until it is first loaded.
- R2: An instruction word holds the opcode in bits [15:12] and the operand address in bits [11:0].
- R3: Each instruction starts with a read (`memEn`=1, `memRw`=1) at the program counter. The read data is taken one cycle after the strobe cycle.
- R4: Opcode 0001 reads the operand address and loads the returned word into the accumulator.
- R5: Opcode 0010 reads the operand address and sets the accumulator to its old value plus the returned word, modulo 2^16.
- R6: Opcode 0011 makes one write (`memEn`=1, `memRw`=0) of the accumulator to the operand address, four cycles after the instruction read. The accumulator is unchanged.
- R7: Opcode 1111 raises `halted`. From then on the core makes no memory access, and `halted` stays high until reset.
- R8: Any other opcode makes no memory access besides its own fetch. It leaves the accumulator unchanged.
- R9: Every instruction other than halt moves the program counter up by one, so successive instruction reads go to successive addresses.
- R10: A strobe is never active in two cycles in a row. Load and add take 8 cycles, store takes 7, a skipped opcode takes 5, and halt reaches the halted state 4 cycles after its fetch begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | 12 | Memory address, driven from the address register |
| memEn | output | 1 | Memory access strobe, one cycle per access |
| memRw | output | 1 | 1 = read, 0 = write; valid while `memEn` is high |
| memRdata | input | 16 | Read data, valid the cycle after a read strobe |
| memWdata | output | 16 | Write data taken from the result bus |
| halted | output | 1 | High while the core sits in the halt state |

## Verification
A corrupted accumulator cannot be seen on a port until the next store. It then shows up as a wrong write value, at most one instruction later in a program that stores after every arithmetic step. A wrong program counter or a wrong state transition shows up at once: the next access goes to an unexpected address or happens in the wrong cycle, and the queue of expected accesses catches it. A halt that is missed or that leaks shows up as a stray fetch after the halt, or as `halted` rising on a cycle other than the expected one.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_LOAD  = 4'b0001,
    OP_ADD   = 4'b0010,
    OP_STORE = 4'b0011,
    OP_HALT  = 4'b1111
  } opcode_e;

  typedef enum logic [1:0] {
    ALU_PASSB = 2'd0,
    ALU_ADD   = 2'd1,
    ALU_PASSA = 2'd2
  } aluOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   pcToAbus;
    logic   irToAbus;
    logic   marLoad;
    logic   memToMbus;
    logic   irLoad;
    logic   mbusToAluB;
    logic   accLoad;
    logic   rbusToMem;
    logic   pcInc;
    aluOp_e aluOp;
    logic   memEn;
    logic   memRw;
  } ctrl_t;
endpackage

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  ctrl_t                     ctrl,
  input  logic [OPC_W+ADDR_W-1:0]   memRdata,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [OPC_W+ADDR_W-1:0]   memWdata,
  output logic [OPC_W-1:0]          opcode
);
  localparam int DATA_W = OPC_W + ADDR_W;

  logic [ADDR_W-1:0] pcReg, marReg;
  logic [DATA_W-1:0] irReg, accReg;
  logic [ADDR_W-1:0] aBus;
  logic [DATA_W-1:0] mBus, rBus, aluB;

  always_comb begin
    if (ctrl.pcToAbus)      aBus = pcReg;
    else if (ctrl.irToAbus) aBus = irReg[ADDR_W-1:0];
    else                    aBus = '0;
  end

  assign mBus = ctrl.memToMbus ? memRdata : '0;
  assign aluB = ctrl.mbusToAluB ? mBus : '0;

  // accumulator is hardwired to ALU input A
  always_comb begin
    case (ctrl.aluOp)
      ALU_ADD:   rBus = accReg + aluB;
      ALU_PASSA: rBus = accReg;
      default:   rBus = aluB;
    endcase
  end

  assign memWdata = ctrl.rbusToMem ? rBus : '0;
  assign memAddr  = marReg;
  assign opcode   = irReg[DATA_W-1 -: OPC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      pcReg  <= '0;
      marReg <= '0;
      irReg  <= '0;
      accReg <= '0;
    end else begin
      if (ctrl.marLoad) marReg <= aBus;
      if (ctrl.irLoad)  irReg  <= mBus;
      if (ctrl.accLoad) accReg <= rBus;
      if (ctrl.pcInc)   pcReg  <= pcReg + 1'b1;
    end
  end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output ctrl_t            ctrl,
  output logic             halted
);
  typedef enum logic [3:0] {
    S_FADDR, S_FRD, S_FLD, S_DEC, S_OADDR,
    S_ORD, S_EXEC, S_STORE, S_PCINC, S_HALT
  } state_e;

  state_e state, nextState;

  always_comb begin
    nextState = state;
    case (state)
      S_FADDR: nextState = S_FRD;
      S_FRD:   nextState = S_FLD;
      S_FLD:   nextState = S_DEC;
      S_DEC: begin
        case (opcode)
          OP_LOAD, OP_ADD, OP_STORE: nextState = S_OADDR;
          OP_HALT:                   nextState = S_HALT;
          default:                   nextState = S_PCINC;
        endcase
      end
      S_OADDR: nextState = (opcode == OP_STORE) ? S_STORE : S_ORD;
      S_ORD:   nextState = S_EXEC;
      S_EXEC:  nextState = S_PCINC;
      S_STORE: nextState = S_PCINC;
      S_PCINC: nextState = S_FADDR;
      S_HALT:  nextState = S_HALT;
      default: nextState = S_FADDR;
    endcase
  end

  always_comb begin
    ctrl = '0;
    ctrl.aluOp = ALU_PASSB;
    case (state)
      S_FADDR: begin ctrl.pcToAbus = 1'b1; ctrl.marLoad = 1'b1; end
      S_FRD:   begin ctrl.memEn = 1'b1; ctrl.memRw = 1'b1; end
      S_FLD:   begin ctrl.memToMbus = 1'b1; ctrl.irLoad = 1'b1; end
      S_OADDR: begin ctrl.irToAbus = 1'b1; ctrl.marLoad = 1'b1; end
      S_ORD:   begin ctrl.memEn = 1'b1; ctrl.memRw = 1'b1; end
      S_EXEC: begin
        ctrl.memToMbus  = 1'b1;
        ctrl.mbusToAluB = 1'b1;
        ctrl.aluOp      = (opcode == OP_ADD) ? ALU_ADD : ALU_PASSB;
        ctrl.accLoad    = 1'b1;
      end
      S_STORE: begin
        ctrl.aluOp     = ALU_PASSA;
        ctrl.rbusToMem = 1'b1;
        ctrl.memEn     = 1'b1;
        ctrl.memRw     = 1'b0;
      end
      S_PCINC: ctrl.pcInc = 1'b1;
      default: ;
    endcase
  end

  assign halted = (state == S_HALT);

  always_ff @(posedge clk) begin
    if (rst) state <= S_FADDR;
    else     state <= nextState;
  end
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic [ADDR_W-1:0]       memAddr,
  output logic                    memEn,
  output logic                    memRw,
  input  logic [OPC_W+ADDR_W-1:0] memRdata,
  output logic [OPC_W+ADDR_W-1:0] memWdata,
  output logic                    halted
);
  ctrl_t            ctrl;
  logic [OPC_W-1:0] opcode;

  acc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .opcode(opcode), .ctrl(ctrl), .halted(halted)
  );

  acc_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .opcode(opcode)
  );

  assign memEn = ctrl.memEn;
  assign memRw = ctrl.memRw;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk (
  input logic clk,
  input logic rst,
  input logic memEn,
  input logic memRw,
  input logic halted
);
  // R7: no access while halted
  p_halt_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    halted |-> !memEn);

  // R7: halt holds until reset
  p_halt_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R10: strobes never back to back
  p_single_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    memEn |=> !memEn);

  // R6: a write comes four cycles after an instruction read
  p_write_after_fetch_r6: assert property (@(posedge clk) disable iff (rst)
    (memEn && !memRw) |-> $past(memEn && memRw, 4));

  // R10: halted only ever entered from a non-access cycle
  p_halt_entry_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> !$past(memEn));
endmodule

bind acc_core acc_core_chk u_chk (
  .clk(clk), .rst(rst), .memEn(memEn), .memRw(memRw), .halted(halted)
);

// File: tb/tb_acc_core.sv
module tb_acc_core;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] memAddr;
  logic              memEn, memRw, halted;
  logic [DATA_W-1:0] memRdata = '0;
  logic [DATA_W-1:0] memWdata;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [ADDR_W-1:0]        rdQ[$];
  logic [ADDR_W+DATA_W-1:0] wrQ[$];
  logic [DATA_W-1:0]        mem [0:(1<<ADDR_W)-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_core #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memEn(memEn), .memRw(memRw),
    .memRdata(memRdata), .memWdata(memWdata), .halted(halted)
  );

  // synchronous memory, one cycle read latency
  always @(posedge clk) begin
    if (memEn && memRw)  memRdata <= mem[memAddr];
    if (memEn && !memRw) mem[memAddr] <= memWdata;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: expected accesses of the whole program
  task automatic pushExpect();
    int fetchRd[11] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10};
    for (int i = 0; i < 11; i++) begin
      rdQ.push_back(fetchRd[i][ADDR_W-1:0]);
      if (i == 1) rdQ.push_back(12'h080);
      if (i == 2) rdQ.push_back(12'h081);
      if (i == 6) rdQ.push_back(12'h082);
      if (i == 7) rdQ.push_back(12'h083);
    end
    wrQ.push_back({12'h100, 16'h0000});  // R1 acc cleared, R6
    wrQ.push_back({12'h101, 16'h2233});  // R4 R5
    wrQ.push_back({12'h102, 16'h2233});  // R8 acc kept
    wrQ.push_back({12'h103, 16'h0001});  // R5 wrap
    wrQ.push_back({12'h104, 16'h0001});  // R6 acc kept
  endtask

  // monitor: pop and compare at negedge
  always @(negedge clk) begin
    if (!rst && memEn && !done) begin
      if (memRw) begin
        if (rdQ.size() == 0) check(1'b0, "R3 R7 R8 R9 unexpected read", {20'h0, memAddr}, 32'hFFFFFFFF);
        else begin
          logic [ADDR_W-1:0] e;
          e = rdQ.pop_front();
          check(memAddr == e, "R3 R9 R2 read address", {20'h0, memAddr}, {20'h0, e});
        end
      end else begin
        if (wrQ.size() == 0) check(1'b0, "R6 R7 R8 unexpected write", {4'h0, memAddr, memWdata}, 32'hFFFFFFFF);
        else begin
          logic [ADDR_W+DATA_W-1:0] e;
          e = wrQ.pop_front();
          check({memAddr, memWdata} == e, "R4 R5 R6 write", {4'h0, memAddr, memWdata}, {4'h0, e});
        end
      end
    end
  end

  task automatic runToHalt();
    repeat (75) @(posedge clk);
    @(negedge clk);
    check(halted == 1'b0, "R10 halt not early", {31'h0, halted}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    check(halted == 1'b1, "R7 R10 halt on cycle 76", {31'h0, halted}, 32'h1);
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(halted == 1'b1, "R7 halt sticky", {31'h0, halted}, 32'h1);
    check(rdQ.size() == 0, "R9 all reads done", rdQ.size(), 0);
    check(wrQ.size() == 0, "R6 all writes done", wrQ.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = '0;
    mem[0]  = 16'h3100;  // store 0x100
    mem[1]  = 16'h1080;  // load
    mem[2]  = 16'h2081;  // add
    mem[3]  = 16'h3101;  // store
    mem[4]  = 16'h5102;  // undefined
    mem[5]  = 16'h3102;  // store
    mem[6]  = 16'h1082;  // load
    mem[7]  = 16'h2083;  // add wraps
    mem[8]  = 16'h3103;  // store
    mem[9]  = 16'h3104;  // store
    mem[10] = 16'hF000;  // halt
    mem[11] = 16'h3105;  // never reached
    mem[12'h080] = 16'h1234;
    mem[12'h081] = 16'h0FFF;
    mem[12'h082] = 16'hFFFF;
    mem[12'h083] = 16'h0002;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(halted == 1'b0, "R1 reset halted low", {31'h0, halted}, 32'h0);
    check(memEn == 1'b0, "R1 reset no strobe", {31'h0, memEn}, 32'h0);
    pushExpect();
    rst = 1'b0;
    runToHalt();

    // reset out of halt, accumulator must restart at zero
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(halted == 1'b0, "R1 reset leaves halt", {31'h0, halted}, 32'h0);
    pushExpect();
    rst = 1'b0;
    runToHalt();
    check(mem[12'h105] == 16'h0000, "R7 nothing after halt", {16'h0, mem[12'h105]}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=halt");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule